// File: doc/BRIEF.md
# Multi-Lane Request Issue Stage

This stage sits between an address generator and a memory request channel. The generator writes requests into a small FIFO owned by the stage. Each entry has to stay in the FIFO for a minimum number of cycles before it may leave. Every cycle the stage offers the oldest eligible entries, in order, on up to `LANES` parallel request lanes. Each lane is a plain valid/ready channel. A lane is offered at most one request per cycle.

When the memory side refuses a request, the stage takes that request out of the FIFO and keeps it in a single hold register. From then on it offers nothing new on any lane. The held request is offered again, on lane 0, in every cycle where the memory side raises `retry_i`. Once that resend is accepted, normal issue from the FIFO resumes in the following cycle.

The stage also keeps three other outputs:
- a count of requests that are accepted but not yet answered;
- a wake pulse for a generator that has stalled, sent after FIFO space is freed;
- an error flag for a retry that arrives when nothing is held.

`DEPTH` must be a power of two and at least 2. `LANES` must not exceed `DEPTH`. The memory side's `req_ready_o` lanes must not depend combinationally on `req_valid_o`.

Top module: `req_issue_stage`

## Requirements
- R1: While reset is asserted and just after it is released, no lane is valid, `outstanding_o` is 0, and `blocked_o`, `buf_full_o`, `gen_wake_o` and `proto_err_o` are all 0.
- R2: A request written in cycle c is offered no earlier than cycle c+`RESIDENCY`. Cycle c is the cycle in which `push_valid_i` is high and the FIFO is not full.
- R3: Lane k carries the k-th oldest buffered request, in bits [k*DW +: DW] of `req_data_o`. Lane k is valid only if lane k-1 is valid and ready in the same cycle, so the valid lanes always form a prefix starting at lane 0.
- R4: Issue in a cycle stops at the first FIFO entry that has not yet met its residency, and also when the FIFO runs out of entries.
- R5: A lane that is valid while its ready is low, and not in a retry cycle, moves its request into the hold register. From the next cycle `blocked_o` is 1, and no lane is valid in any cycle where `retry_i` is low.
- R6: While blocked, a cycle with `retry_i` high offers the held request on lane 0 and on no other lane. If lane 0 is ready in that cycle, `blocked_o` falls in the next cycle and FIFO issue resumes in that cycle. If lane 0 is not ready, the stage stays blocked.
- R7: `outstanding_o` rises by the number of accepted lanes (valid and ready) and falls by one on `rsp_valid_i`. A response that arrives while the count would be zero is ignored.
- R8: `gen_wake_o` is 1 in the cycle after any cycle in which at least one entry left the FIFO while `gen_sleep_i` was 1. It is 0 otherwise. Resending the held request does not free FIFO space.
- R9: `retry_i` high while nothing is held sets `proto_err_o` in the next cycle. It causes no request to be offered.
- R10: `buf_full_o` is 1 while the FIFO holds `DEPTH` entries. A write attempted while it is full is dropped and never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid_i | input | 1 | Write a request into the FIFO |
| push_data_i | input | DW | Request word to write |
| buf_full_o | output | 1 | FIFO holds DEPTH entries |
| gen_sleep_i | input | 1 | Generator is stalled waiting for space |
| gen_wake_o | output | 1 | Space was freed last cycle while the generator was stalled |
| req_valid_o | output | LANES | Per-lane request valid |
| req_data_o | output | LANES*DW | Per-lane request words, lane k at [k*DW +: DW] |
| req_ready_i | input | LANES | Per-lane acceptance from memory |
| retry_i | input | 1 | Memory side invites a resend of the held request |
| rsp_valid_i | input | 1 | One response returned |
| outstanding_o | output | OUT_W | Accepted requests not yet answered |
| blocked_o | output | 1 | A refused request is held |
| proto_err_o | output | 1 | Retry arrived with nothing held |

## Verification
The bench builds the stage with two lanes, a four-entry FIFO, a residency of two cycles, 8-bit requests and a 4-bit outstanding count. With two lanes, both the dual-lane issue and the lane-1 suppression after a lane-0 refusal can be shown. With four entries, the FIFO fills after a handful of writes made while blocked, so a dropped write can be seen. A residency of two leaves a visible cycle in which a fresh entry sits in the FIFO without being offered. It also lets two entries age together behind a held request and then leave side by side.

// File: rtl/req_issue_pkg.sv
package req_issue_pkg;

  typedef enum logic {
    HOLD_IDLE = 1'b0,
    HOLD_BUSY = 1'b1
  } hold_e;

  // Bits needed to count 0..n inclusive
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/iss_fifo.sv
module iss_fifo
  import req_issue_pkg::*;
#(
  parameter int DW        = 32,
  parameter int DEPTH     = 16,
  parameter int LANES     = 4,
  parameter int RESIDENCY = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic [cnt_bits(LANES)-1:0] pop_n_i,
  output logic                      full_o,
  output logic [LANES*DW-1:0]       win_data_o,
  output logic [LANES-1:0]          win_ok_o
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = cnt_bits(DEPTH);
  localparam int AGE_W = cnt_bits(RESIDENCY);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(RESIDENCY);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [AGE_W-1:0] age_q [DEPTH];
  logic [AGE_W-1:0] age_d [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_ok;

  assign full_o = (cnt_q == CNT_W'(DEPTH));
  assign wr_ok  = wr_en_i && !full_o;

  // Next state: pointers, occupancy, per-slot residency age (saturating)
  always_comb begin
    rd_d  = rd_q + PTR_W'(pop_n_i);
    wr_d  = wr_ok ? (wr_q + PTR_W'(1)) : wr_q;
    cnt_d = cnt_q + CNT_W'(wr_ok) - CNT_W'(pop_n_i);
    for (int k = 0; k < DEPTH; k++) begin
      if (wr_ok && (wr_q == PTR_W'(k))) begin
        age_d[k] = AGE_W'(1);
      end else if (age_q[k] != AGE_MAX) begin
        age_d[k] = age_q[k] + AGE_W'(1);
      end else begin
        age_d[k] = age_q[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int k = 0; k < DEPTH; k++) age_q[k] <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
      for (int k = 0; k < DEPTH; k++) age_q[k] <= age_d[k];
    end
  end

  // Storage array: data only, written under enable, no reset
  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wr_q] <= wr_data_i;
  end

  // Head window seen by the lanes
  for (genvar g = 0; g < LANES; g++) begin : g_win
    logic [PTR_W-1:0] slot;
    assign slot = rd_q + PTR_W'(g);
    assign win_data_o[g*DW +: DW] = mem_q[slot];
    assign win_ok_o[g] = (cnt_q > CNT_W'(g)) && (age_q[slot] == AGE_MAX);
  end

endmodule

// File: rtl/iss_lanes.sv
module iss_lanes
  import req_issue_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic [LANES*DW-1:0]        win_data_i,
  input  logic [LANES-1:0]           win_ok_i,
  input  logic                       held_i,
  input  logic [DW-1:0]              hold_data_i,
  input  logic                       retry_i,
  input  logic [LANES-1:0]           rdy_i,
  output logic [LANES-1:0]           valid_o,
  output logic [LANES*DW-1:0]        data_o,
  output logic [cnt_bits(LANES)-1:0] pop_n_o,
  output logic [cnt_bits(LANES)-1:0] acc_n_o,
  output logic                       refuse_o,
  output logic [DW-1:0]              refuse_data_o
);

  localparam int LW = cnt_bits(LANES);

  logic [LANES-1:0] v;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_first
      assign v[0] = held_i ? retry_i : win_ok_i[0];
      assign data_o[DW-1:0] = held_i ? hold_data_i : win_data_i[DW-1:0];
    end else begin : g_rest
      // lane g only goes out behind an accepted lane g-1
      assign v[g] = !held_i && win_ok_i[g] && v[g-1] && rdy_i[g-1];
      assign data_o[g*DW +: DW] = win_data_i[g*DW +: DW];
    end
  end

  assign valid_o  = v;
  assign pop_n_o  = held_i ? '0 : LW'($countones(v));
  assign acc_n_o  = LW'($countones(v & rdy_i));
  assign refuse_o = !held_i && |(v & ~rdy_i);

  always_comb begin
    refuse_data_o = win_data_i[DW-1:0];
    for (int k = 0; k < LANES; k++) begin
      if (v[k] && !rdy_i[k]) refuse_data_o = win_data_i[k*DW +: DW];
    end
  end

endmodule

// File: rtl/iss_track.sv
module iss_track
  import req_issue_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LANES = 4,
  parameter int OUT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       refuse_i,
  input  logic [DW-1:0]              refuse_data_i,
  input  logic                       retry_i,
  input  logic                       rdy0_i,
  input  logic [cnt_bits(LANES)-1:0] acc_n_i,
  input  logic                       rsp_i,
  input  logic                       pop_any_i,
  input  logic                       sleep_i,
  output logic                       held_o,
  output logic [DW-1:0]              hold_data_o,
  output logic [OUT_W-1:0]           outstanding_o,
  output logic                       wake_o,
  output logic                       err_o
);

  hold_e            hold_q, hold_d;
  logic [DW-1:0]    hdat_q;
  logic             hdat_en;
  logic [OUT_W-1:0] out_q, out_d, sum;
  logic             wake_q, wake_d, err_q, err_d;

  always_comb begin
    hold_d  = hold_q;
    hdat_en = 1'b0;
    if (hold_q == HOLD_BUSY) begin
      if (retry_i && rdy0_i) hold_d = HOLD_IDLE;
    end else if (refuse_i) begin
      hold_d  = HOLD_BUSY;
      hdat_en = 1'b1;
    end
    sum    = out_q + OUT_W'(acc_n_i);
    out_d  = (rsp_i && (sum != '0)) ? (sum - OUT_W'(1)) : sum;
    wake_d = pop_any_i && sleep_i;
    err_d  = retry_i && (hold_q == HOLD_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= HOLD_IDLE;
      out_q  <= '0;
      wake_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      out_q  <= out_d;
      wake_q <= wake_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hdat_en) hdat_q <= refuse_data_i;
  end

  assign held_o        = (hold_q == HOLD_BUSY);
  assign hold_data_o   = hdat_q;
  assign outstanding_o = out_q;
  assign wake_o        = wake_q;
  assign err_o         = err_q;

endmodule

// File: rtl/req_issue_stage.sv
module req_issue_stage
  import req_issue_pkg::*;
#(
  parameter int DW        = 32,
  parameter int LANES     = 4,
  parameter int DEPTH     = 16,
  parameter int RESIDENCY = 1,
  parameter int OUT_W     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_valid_i,
  input  logic [DW-1:0]       push_data_i,
  output logic                buf_full_o,
  input  logic                gen_sleep_i,
  output logic                gen_wake_o,
  output logic [LANES-1:0]    req_valid_o,
  output logic [LANES*DW-1:0] req_data_o,
  input  logic [LANES-1:0]    req_ready_i,
  input  logic                retry_i,
  input  logic                rsp_valid_i,
  output logic [OUT_W-1:0]    outstanding_o,
  output logic                blocked_o,
  output logic                proto_err_o
);

  localparam int LW = cnt_bits(LANES);

  logic [LANES*DW-1:0] win_data;
  logic [LANES-1:0]    win_ok;
  logic [LW-1:0]       pop_n, acc_n;
  logic                refuse, held;
  logic [DW-1:0]       refuse_data, hold_data;

  iss_fifo #(.DW(DW), .DEPTH(DEPTH), .LANES(LANES), .RESIDENCY(RESIDENCY)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (push_valid_i),
    .wr_data_i  (push_data_i),
    .pop_n_i    (pop_n),
    .full_o     (buf_full_o),
    .win_data_o (win_data),
    .win_ok_o   (win_ok)
  );

  iss_lanes #(.DW(DW), .LANES(LANES)) u_lanes (
    .win_data_i    (win_data),
    .win_ok_i      (win_ok),
    .held_i        (held),
    .hold_data_i   (hold_data),
    .retry_i       (retry_i),
    .rdy_i         (req_ready_i),
    .valid_o       (req_valid_o),
    .data_o        (req_data_o),
    .pop_n_o       (pop_n),
    .acc_n_o       (acc_n),
    .refuse_o      (refuse),
    .refuse_data_o (refuse_data)
  );

  iss_track #(.DW(DW), .LANES(LANES), .OUT_W(OUT_W)) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .refuse_i      (refuse),
    .refuse_data_i (refuse_data),
    .retry_i       (retry_i),
    .rdy0_i        (req_ready_i[0]),
    .acc_n_i       (acc_n),
    .rsp_i         (rsp_valid_i),
    .pop_any_i     (pop_n != '0),
    .sleep_i       (gen_sleep_i),
    .held_o        (held),
    .hold_data_o   (hold_data),
    .outstanding_o (outstanding_o),
    .wake_o        (gen_wake_o),
    .err_o         (proto_err_o)
  );

  assign blocked_o = held;

endmodule

// File: rtl/req_issue_stage_chk.sv
module req_issue_stage_chk #(
  parameter int LANES = 4,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_sleep_i,
  input logic             gen_wake_o,
  input logic             buf_full_o,
  input logic [LANES-1:0] req_valid_o,
  input logic [LANES-1:0] req_ready_i,
  input logic             retry_i,
  input logic             rsp_valid_i,
  input logic [OUT_W-1:0] outstanding_o,
  input logic             blocked_o,
  input logic             proto_err_o
);

  AST_LANE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    ((LANES'(req_valid_o + 1'b1) & req_valid_o) == '0)); // R3

  AST_BLOCK_ON_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!blocked_o && |(req_valid_o & ~req_ready_i)) |=> blocked_o); // R5

  AST_QUIET_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked_o && !retry_i) |-> (req_valid_o == '0)); // R5

  AST_RETRY_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked_o && retry_i) |-> (req_valid_o == LANES'(1))); // R6

  AST_RETRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked_o && retry_i && req_ready_i[0]) |=> !blocked_o); // R6

  AST_OUT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid_i |=> (outstanding_o ==
      OUT_W'($past(outstanding_o) + OUT_W'($countones($past(req_valid_o & req_ready_i)))))); // R7

  AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    gen_wake_o |-> $past(gen_sleep_i)); // R8

  AST_STRAY_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_i && !blocked_o) |=> proto_err_o); // R9

  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full_o && (req_valid_o == '0)) |=> buf_full_o); // R10

endmodule

bind req_issue_stage req_issue_stage_chk #(.LANES(LANES), .OUT_W(OUT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .gen_sleep_i   (gen_sleep_i),
  .gen_wake_o    (gen_wake_o),
  .buf_full_o    (buf_full_o),
  .req_valid_o   (req_valid_o),
  .req_ready_i   (req_ready_i),
  .retry_i       (retry_i),
  .rsp_valid_i   (rsp_valid_i),
  .outstanding_o (outstanding_o),
  .blocked_o     (blocked_o),
  .proto_err_o   (proto_err_o)
);

// File: tb/sim_req_issue_stage.sv
`timescale 1ns/1ps
module sim_req_issue_stage;

  localparam int DW = 8, LANES = 2, DEPTH = 4, RES = 2, OUT_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic push_v, rtry, rsp, slp;
  logic [DW-1:0] push_d;
  logic [LANES-1:0] rdy;
  logic buf_full, wake, blk, perr;
  logic [LANES-1:0] rv;
  logic [LANES*DW-1:0] rd;
  logic [OUT_W-1:0] outs;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  req_issue_stage #(.DW(DW), .LANES(LANES), .DEPTH(DEPTH), .RESIDENCY(RES), .OUT_W(OUT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .push_valid_i(push_v), .push_data_i(push_d),
    .buf_full_o(buf_full), .gen_sleep_i(slp), .gen_wake_o(wake),
    .req_valid_o(rv), .req_data_o(rd), .req_ready_i(rdy), .retry_i(rtry),
    .rsp_valid_i(rsp), .outstanding_o(outs), .blocked_o(blk), .proto_err_o(perr)
  );

  // Layout: pv | pd[8] | rdy[2] | retry | rsp | sleep || ev[2] | ed0[8] | ed1[8] | eblk | eout[4] | ewake
  localparam logic [37:0] TBL [16] = '{
    {1'b1, 8'h11, 2'b11, 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h00, 1'b0, 4'd0, 1'b0},
    {1'b1, 8'h22, 2'b11, 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h00, 1'b0, 4'd0, 1'b0},
    {1'b0, 8'h00, 2'b11, 1'b0, 1'b0, 1'b0, 2'b01, 8'h11, 8'h00, 1'b0, 4'd0, 1'b0},
    {1'b0, 8'h00, 2'b11, 1'b0, 1'b0, 1'b0, 2'b01, 8'h22, 8'h00, 1'b0, 4'd1, 1'b0},
    {1'b0, 8'h00, 2'b11, 1'b0, 1'b1, 1'b0, 2'b00, 8'h00, 8'h00, 1'b0, 4'd2, 1'b0},
    {1'b1, 8'h33, 2'b11, 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h00, 1'b0, 4'd1, 1'b0},
    {1'b1, 8'h44, 2'b11, 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h00, 1'b0, 4'd1, 1'b0},
    {1'b1, 8'h55, 2'b00, 1'b0, 1'b0, 1'b0, 2'b01, 8'h33, 8'h00, 1'b0, 4'd1, 1'b0},
    {1'b1, 8'h66, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h00, 1'b1, 4'd1, 1'b0},
    {1'b0, 8'h00, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h00, 1'b1, 4'd1, 1'b0},
    {1'b0, 8'h00, 2'b01, 1'b1, 1'b0, 1'b0, 2'b01, 8'h33, 8'h00, 1'b1, 4'd1, 1'b0},
    {1'b0, 8'h00, 2'b11, 1'b0, 1'b0, 1'b1, 2'b11, 8'h44, 8'h55, 1'b0, 4'd2, 1'b0},
    {1'b0, 8'h00, 2'b11, 1'b0, 1'b0, 1'b0, 2'b01, 8'h66, 8'h00, 1'b0, 4'd4, 1'b1},
    {1'b0, 8'h00, 2'b11, 1'b0, 1'b1, 1'b0, 2'b00, 8'h00, 8'h00, 1'b0, 4'd5, 1'b0},
    {1'b0, 8'h00, 2'b11, 1'b0, 1'b1, 1'b0, 2'b00, 8'h00, 8'h00, 1'b0, 4'd4, 1'b0},
    {1'b0, 8'h00, 2'b11, 1'b0, 1'b0, 1'b0, 2'b00, 8'h00, 8'h00, 1'b0, 4'd3, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, settle, then the caller checks
  task automatic apply(input logic pv, input logic [7:0] pd, input logic [1:0] r,
                       input logic rt, input logic rs, input logic sl);
    @(negedge clk);
    push_v = pv; push_d = pd; rdy = r; rtry = rt; rsp = rs; slp = sl;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    push_v = 0; push_d = 0; rdy = 0; rtry = 0; rsp = 0; slp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 valid", int'(rv), 0);
    chk("R1 outstanding", int'(outs), 0);
    chk("R1 blocked", int'(blk), 0);
    chk("R1 full", int'(buf_full), 0);
    chk("R1 wake", int'(wake), 0);
    chk("R1 proto_err", int'(perr), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    push_v = 0; push_d = 0; rdy = 0; rtry = 0; rsp = 0; slp = 0;
    do_reset();

    // Table: R2 residency, R3 dual lane, R4 stop, R5 hold, R6 retry, R7 count, R8 wake
    for (int i = 0; i < 16; i++) begin
      logic [37:0] t;
      t = TBL[i];
      apply(t[37], t[36:29], t[28:27], t[26], t[25], t[24]);
      chk($sformatf("R2/R3/R4 v%0d valid", i), int'(rv), int'(t[23:22]));
      if (t[22]) chk($sformatf("R3 v%0d lane0 data", i), int'(rd[7:0]), int'(t[21:14]));
      if (t[23]) chk($sformatf("R3 v%0d lane1 data", i), int'(rd[15:8]), int'(t[13:6]));
      chk($sformatf("R5/R6 v%0d blocked", i), int'(blk), int'(t[5]));
      chk($sformatf("R7 v%0d outstanding", i), int'(outs), int'(t[4:1]));
      chk($sformatf("R8 v%0d wake", i), int'(wake), int'(t[0]));
    end

    // Directed: response at zero count is ignored (R7)
    do_reset();
    apply(0, 8'h00, 2'b00, 0, 1, 0);
    apply(0, 8'h00, 2'b00, 0, 0, 0);
    chk("R7 response at zero ignored", int'(outs), 0);

    // Directed: stray retry (R9)
    apply(0, 8'h00, 2'b11, 1, 0, 0);
    chk("R9 no request on stray retry", int'(rv), 0);
    apply(0, 8'h00, 2'b11, 0, 0, 0);
    chk("R9 proto_err", int'(perr), 1);
    chk("R9 not blocked", int'(blk), 0);

    // Directed: fill while blocked, dropped write, lane chaining
    apply(1, 8'hA0, 2'b00, 0, 0, 0);
    apply(1, 8'hA1, 2'b00, 0, 0, 0);
    apply(1, 8'hA2, 2'b00, 0, 0, 0);
    chk("R5 refused lane0 valid", int'(rv), 1);
    chk("R5 refused lane0 data", int'(rd[7:0]), 'hA0);
    apply(1, 8'hA3, 2'b00, 0, 0, 0);
    chk("R5 blocked after refuse", int'(blk), 1);
    chk("R5 quiet while blocked", int'(rv), 0);
    apply(1, 8'hA4, 2'b11, 0, 0, 0);
    chk("R10 not yet full", int'(buf_full), 0);
    chk("R5 quiet despite ready", int'(rv), 0);
    apply(1, 8'hA5, 2'b00, 0, 0, 0);
    chk("R10 full", int'(buf_full), 1);
    apply(0, 8'h00, 2'b11, 1, 0, 0);
    chk("R6 retry offers lane0 only", int'(rv), 1);
    chk("R6 retry resends held", int'(rd[7:0]), 'hA0);
    apply(0, 8'h00, 2'b10, 0, 0, 0);
    chk("R6 unblocked after retry", int'(blk), 0);
    chk("R3 lane1 suppressed behind refused lane0", int'(rv), 1);
    chk("R3 lane0 oldest", int'(rd[7:0]), 'hA1);
    apply(0, 8'h00, 2'b01, 1, 0, 1);
    chk("R6 second retry data", int'(rd[7:0]), 'hA1);
    chk("R6 still blocked", int'(blk), 1);
    apply(0, 8'h00, 2'b11, 0, 0, 1);
    chk("R8 no wake for held resend", int'(wake), 0);
    chk("R3 dual lane", int'(rv), 3);
    chk("R3 lane0 data", int'(rd[7:0]), 'hA2);
    chk("R3 lane1 data", int'(rd[15:8]), 'hA3);
    apply(0, 8'h00, 2'b11, 0, 0, 0);
    chk("R8 wake after pop", int'(wake), 1);
    chk("R4 last entry only", int'(rv), 1);
    chk("R4 last entry data", int'(rd[7:0]), 'hA4);
    apply(0, 8'h00, 2'b11, 0, 0, 0);
    chk("R10 dropped write never issued", int'(rv), 0);
    chk("R7 accepted count", int'(outs), 5);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule